// File: doc/BRIEF.md
# Triangular-Window Averaging Filter

This block smooths a stream of signed sensor samples with a triangular (Bartlett) weighting. It is built from two identical moving-average stages of length N placed in series. Cascading two boxcars gives the square of one boxcar's frequency response, which is a triangular impulse response spanning 2N-1 samples. No multipliers are used. Each stage keeps a running sum, a circular history buffer and a normalising arithmetic right shift.

The window length is a power of two, N = 2^M, where M comes from a 3-bit configuration input. When M changes, the history is flushed and the filter settles again from zero. The output carries a valid strobe that stays low until the window is full of real data. Samples arrive with a valid strobe, and each accepted sample produces at most one registered output one clock later.

Top module: `tri_avg_filter`

## Requirements
- R1: While reset is asserted and right after it, out_valid_o is 0 and out_data_o is 0, and the active window exponent is 0.
- R2: The window length is N = 2^m_i. All values 0..7 of the 3-bit m_i are legal, so N ranges over 1, 2, 4, ... 128.
- R3: Let x(k) be the k-th sample accepted since the last flush, with x(j) = 0 for j < 0. Then s(k) = floor(sum of x(k-N+1..k) / N), and the output for sample k is floor(sum of s(k-N+1..k) / N). The floor is taken toward minus infinity.
- R4: A sample is accepted on a rising clock edge where in_valid_i is 1 and m_i equals the active exponent. Its result appears on out_data_o after that same edge, so the latency is one cycle.
- R5: With m_i = 0 the filter is a pure one-cycle delay: out_data_o equals the previous accepted sample, and out_valid_o is 1 for every accepted sample.
- R6: out_valid_o is 1 after the edge that accepts sample k exactly when k >= 2N-2, that is, from the (2N-1)-th sample after a flush onward.
- R7: On an edge where m_i differs from the active exponent, a flush happens. The new exponent becomes active, both stages' history and sums clear, out_valid_o and out_data_o go to 0, and any sample presented on that edge is discarded.
- R8: On an edge without an accepted sample and without a flush, out_valid_o is 0 and out_data_o keeps its value.
- R9: Full-scale inputs (-32768 and +32767 with 16-bit samples) at N = 128 produce exact results with no wrap. Each running sum carries 7 guard bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| m_i | input | 3 | Window exponent, N = 2^m_i |
| in_valid_i | input | 1 | Input sample strobe |
| in_data_i | input | 16 | Signed input sample |
| out_valid_o | output | 1 | Filtered sample strobe |
| out_data_o | output | 16 | Signed filtered sample |

## Verification
Two events can fall in the same cycle: a change of the exponent, which flushes the filter, and an input sample. The bench provokes this by moving m_i and raising in_valid_i with a non-zero sample on the same edge. It judges the outcome in two ways. First, out_valid_o must stay low and out_data_o must read zero one cycle later. Second, the following samples must match a reference model that never saw the discarded sample, so that any leak into a history buffer shows up as a wrong output once the window fills.

// File: rtl/tri_avg_pkg.sv
package tri_avg_pkg;
  typedef struct packed {
    logic take;     // sample accepted this cycle
    logic flush;    // exponent change, clear history
    logic sub_en;   // sample N back exists
    logic warm_ok;  // output will be valid
  } tri_ctl_t;
endpackage

// File: rtl/tri_avg_ctrl.sv
module tri_avg_ctrl import tri_avg_pkg::*; #(
  parameter int M_MAX = 7,
  parameter int M_W   = $clog2(M_MAX + 1),
  parameter int A_W   = M_MAX
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [M_W-1:0] m_i,
  input  logic           in_valid_i,
  output tri_ctl_t       ctl_o,
  output logic [M_W-1:0] m_q_o,
  output logic [A_W-1:0] wptr_o
);
  localparam int CNT_W = M_MAX + 1;

  logic [M_W-1:0]   m_q;
  logic [CNT_W-1:0] cnt_q;
  logic [A_W-1:0]   wptr_q;
  logic [CNT_W:0]   len;
  logic [CNT_W:0]   warm_thr;

  assign len      = (CNT_W+1)'(1) << m_q;
  assign warm_thr = ((CNT_W+1)'(2) << m_q) - (CNT_W+1)'(2);

  always_comb begin
    ctl_o.flush   = (m_i != m_q);
    ctl_o.take    = in_valid_i && !ctl_o.flush;
    ctl_o.sub_en  = {1'b0, cnt_q} >= len;
    ctl_o.warm_ok = {1'b0, cnt_q} >= warm_thr;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q    <= '0;
      cnt_q  <= '0;
      wptr_q <= '0;
    end else if (ctl_o.flush) begin
      m_q   <= m_i;
      cnt_q <= '0;
    end else if (ctl_o.take) begin
      wptr_q <= wptr_q + A_W'(1);
      if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  assign m_q_o  = m_q;
  assign wptr_o = wptr_q;
endmodule

// File: rtl/tri_avg_boxcar.sv
module tri_avg_boxcar #(
  parameter int DATA_W = 16,
  parameter int M_MAX  = 7,
  parameter int M_W    = $clog2(M_MAX + 1),
  parameter int A_W    = M_MAX
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic                     take_i,
  input  logic                     sub_en_i,
  input  logic [M_W-1:0]           m_i,
  input  logic [A_W-1:0]           wptr_i,
  input  logic signed [DATA_W-1:0] x_i,
  output logic signed [DATA_W-1:0] y_o
);
  localparam int DEPTH = 1 << M_MAX;
  localparam int ACC_W = DATA_W + M_MAX;  // guard bits cover N = 2^M_MAX

  logic signed [DATA_W-1:0] hist_q [DEPTH];
  logic signed [ACC_W-1:0]  acc_q, acc_nxt;
  logic signed [DATA_W-1:0] old;
  logic [A_W:0]             len;
  logic [A_W-1:0]           rptr;

  assign len  = (A_W+1)'(1) << m_i;
  assign rptr = wptr_i - len[A_W-1:0];  // wraps to the slot being overwritten at N = DEPTH
  assign old  = sub_en_i ? hist_q[rptr] : '0;

  assign acc_nxt = acc_q + ACC_W'(x_i) - ACC_W'(old);
  assign y_o     = DATA_W'(acc_nxt >>> m_i);

  always_ff @(posedge clk_i) begin
    if (take_i) hist_q[wptr_i] <= x_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      acc_q <= '0;
    else if (flush_i) acc_q <= '0;
    else if (take_i)  acc_q <= acc_nxt;
  end
endmodule

// File: rtl/tri_avg_filter.sv
module tri_avg_filter import tri_avg_pkg::*; #(
  parameter int DATA_W = 16,
  parameter int M_MAX  = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(M_MAX+1)-1:0] m_i,
  input  logic                     in_valid_i,
  input  logic signed [DATA_W-1:0] in_data_i,
  output logic                     out_valid_o,
  output logic signed [DATA_W-1:0] out_data_o
);
  localparam int M_W     = $clog2(M_MAX + 1);
  localparam int A_W     = M_MAX;
  localparam int N_STAGE = 2;

  tri_ctl_t       ctl;
  logic [M_W-1:0] m_q;
  logic [A_W-1:0] wptr;
  logic signed [DATA_W-1:0] stage_x [N_STAGE+1];

  tri_avg_ctrl #(.M_MAX(M_MAX), .M_W(M_W), .A_W(A_W)) u_ctrl (
    .clk_i, .rst_ni, .m_i, .in_valid_i,
    .ctl_o(ctl), .m_q_o(m_q), .wptr_o(wptr)
  );

  assign stage_x[0] = in_data_i;

  for (genvar s = 0; s < N_STAGE; s++) begin : g_stage
    tri_avg_boxcar #(.DATA_W(DATA_W), .M_MAX(M_MAX), .M_W(M_W), .A_W(A_W)) u_box (
      .clk_i, .rst_ni,
      .flush_i(ctl.flush), .take_i(ctl.take), .sub_en_i(ctl.sub_en),
      .m_i(m_q), .wptr_i(wptr),
      .x_i(stage_x[s]), .y_o(stage_x[s+1])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else if (ctl.flush) begin
      out_valid_o <= 1'b0;
      out_data_o  <= '0;
    end else begin
      out_valid_o <= ctl.take && ctl.warm_ok;
      if (ctl.take) out_data_o <= stage_x[N_STAGE];
    end
  end
endmodule

// File: rtl/tri_avg_filter_chk.sv
module tri_avg_filter_chk #(
  parameter int DATA_W = 16,
  parameter int M_W    = 3
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic [M_W-1:0]           m_i,
  input logic                     in_valid_i,
  input logic signed [DATA_W-1:0] in_data_i,
  input logic                     out_valid_o,
  input logic signed [DATA_W-1:0] out_data_o,
  input logic [M_W-1:0]           m_q_i
);
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && m_i == '0 && m_q_i == '0) |=> (out_valid_o && out_data_o == $past(in_data_i))); // R5

  AST_FLUSH_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i != m_q_i) |=> (!out_valid_o && out_data_o == '0)); // R7

  AST_CFG_TRACKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i != m_q_i) |=> (m_q_i == $past(m_i))); // R7

  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_valid_i && m_i == m_q_i) |=> (!out_valid_o && $stable(out_data_o))); // R8
endmodule

bind tri_avg_filter tri_avg_filter_chk #(.DATA_W(DATA_W), .M_W(M_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .m_i(m_i), .in_valid_i(in_valid_i),
  .in_data_i(in_data_i), .out_valid_o(out_valid_o), .out_data_o(out_data_o),
  .m_q_i(m_q)
);

// File: tb/tri_avg_filter_bench.sv
module tri_avg_filter_bench;
  localparam int DW = 16;

  logic                 clk = 1'b0;
  logic                 rst_ni = 1'b0;
  logic [2:0]           m_i = '0;
  logic                 in_valid_i = 1'b0;
  logic signed [DW-1:0] in_data_i = '0;
  logic                 out_valid_o;
  logic signed [DW-1:0] out_data_o;

  int total = 0;
  int bad   = 0;
  int cur_m = 0;
  int n_hist = 0;
  int xs [2048];
  int s1 [2048];
  logic [15:0] lfsr = 16'hACE1;

  always #10 clk = ~clk;

  tri_avg_filter #(.DATA_W(DW), .M_MAX(7)) u_tri_avg_filter (
    .clk_i(clk), .rst_ni, .m_i, .in_valid_i, .in_data_i, .out_valid_o, .out_data_o
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // drive at a negedge, judge at the next negedge
  task automatic step(input bit v, input int x, input int m, input string tag);
    bit flush;
    int prev, sum, nl, y;
    bit expv;
    flush = (m != cur_m);
    prev  = int'(out_data_o);
    m_i = 3'(m); in_valid_i = v; in_data_i = DW'(x);
    @(negedge clk);
    in_valid_i = 1'b0;
    if (flush) begin
      chk(out_valid_o == 1'b0, "R7 valid", int'(out_valid_o), 0);
      chk(out_data_o == 0, "R7 data", int'(out_data_o), 0);
      cur_m = m; n_hist = 0;
    end else if (v) begin
      nl = 1 << m;
      xs[n_hist] = x;
      sum = 0;
      for (int j = n_hist - nl + 1; j <= n_hist; j++) if (j >= 0) sum += xs[j];
      s1[n_hist] = sum >>> m;
      sum = 0;
      for (int j = n_hist - nl + 1; j <= n_hist; j++) if (j >= 0) sum += s1[j];
      y = sum >>> m;
      expv = (n_hist >= 2*nl - 2);
      chk(out_valid_o == expv, "R6 valid", int'(out_valid_o), int'(expv));
      if (expv) chk(int'(out_data_o) == y, tag, int'(out_data_o), y);
      n_hist++;
    end else begin
      chk(out_valid_o == 1'b0, "R8 valid", int'(out_valid_o), 0);
      chk(int'(out_data_o) == prev, "R8 data", int'(out_data_o), prev);
    end
  endtask

  function automatic int next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return int'($signed(lfsr));
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid_o == 1'b0, "R1 valid", int'(out_valid_o), 0);
    chk(out_data_o == 0, "R1 data", int'(out_data_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(out_valid_o == 1'b0 && out_data_o == 0, "R1 after release", int'(out_data_o), 0);

    // R5: pass-through at m = 0, back to back then with gaps
    for (int i = 0; i < 20; i++) step(1'b1, next_rand(), 0, "R5 data");
    for (int i = 0; i < 6; i++) begin
      step(1'b1, next_rand(), 0, "R5 data");
      step(1'b0, 0, 0, "R8");
    end

    // R2 R3 R4: sweep every window length with random data and gaps
    for (int m = 1; m <= 7; m++) begin
      step(1'b0, 0, m, "R7");
      for (int i = 0; i < (2 << m) + 12; i++) begin
        step(1'b1, next_rand(), m, "R3 data");
        if (i % 7 == 3) step(1'b0, 0, m, "R8");
      end
    end

    // R7: flush coinciding with a sample, history must not keep it
    step(1'b0, 0, 3, "R7");
    for (int i = 0; i < 20; i++) step(1'b1, next_rand(), 3, "R3 data");
    step(1'b1, 12345, 2, "R7");
    for (int i = 0; i < 14; i++) step(1'b1, next_rand(), 2, "R7 data");
    step(1'b1, -4000, 0, "R7");
    step(1'b1, 77, 0, "R5 data");

    // R9: full scale at N = 128
    step(1'b0, 0, 7, "R7");
    for (int i = 0; i < 260; i++) step(1'b1, -32768, 7, "R9 data");
    for (int i = 0; i < 260; i++) step(1'b1, 32767, 7, "R9 data");
    for (int i = 0; i < 40; i++) step(1'b1, (i % 2) ? 32767 : -32768, 7, "R9 data");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule